// File: doc/BRIEF.md
# Two-Pipe Instruction Pairing and Issue Stage

This block sits between an instruction queue and two integer execution pipes, called U and V. In every cycle it looks at the two oldest queue entries together. It decides whether both can leave in that cycle: the older one on U and the younger one on V. If they cannot, only the older one leaves, on U, and V gets a bubble. Each pipe then runs five stages (fetch, two decode steps, execute, write-back). Those pipes are outside this block.

A pair may issue together only when two conditions hold. The younger instruction must be classed simple, because V only runs simple integer operations. The younger instruction must also not depend on the older one. A dependency is either of these:
- the older instruction writes a register that the younger one reads;
- both instructions write the same register.

The older instruction always goes to U and is never swapped onto V, so program order is kept across the pipes.

The block computes a pop count for the queue in the same cycle, from the head entries. The chosen instructions are captured in one issue register per pipe and appear on the pipe outputs on the following cycle. A downstream stall freezes the issue registers and stops popping. A flush hides the issue outputs at once and empties the issue registers.

Top module: `dual_issue_steer`

## Requirements
- R1: After reset, with an empty queue, `u_valid`, `v_valid` and `pop` are all 0.
- R2: When neither stall nor flush is asserted, `pop` is 2 on a dual issue, 1 on a single issue and 0 when `q_valid[0]` is 0. `q_valid[1]` is only considered when `q_valid[0]` is 1.
- R3: An instruction word is laid out as {tag[16], simple[1], writes[1], dst[5], srcb[5], srca[5]}, with srca in bits 4:0, srcb in 9:5, dst in 14:10, writes in bit 15, simple in bit 16 and tag in 32:17. A dual issue happens when both entries are valid, entry 1 has simple=1 and no dependency exists. On the next cycle `u_insn` equals entry 0, `v_insn` equals entry 1 and both valids are 1.
- R4: A read-after-write dependency forces a single issue to U with `v_valid` 0 on the next cycle. This is the case when entry 0 has writes=1 and its dst equals srca or srcb of entry 1.
- R5: A write-after-write dependency forces a single issue. This is the case when both entries have writes=1 and equal dst.
- R6: An entry 1 with simple=0 is never issued to V. The pair then issues singly.
- R7: With only entry 0 valid, entry 0 issues alone to U.
- R8: While `stall` is 1, `pop` is 0 and `u_valid`, `v_valid`, `u_insn` and `v_insn` keep their values.
- R9: While `flush` is 1, `u_valid`, `v_valid` and `pop` are 0 in that same cycle, and both valids are still 0 on the next cycle.
- R10: A matching register number does not block pairing when entry 0 has writes=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_valid | input | 2 | Valid flags of queue entries 0 (oldest) and 1 |
| q0_insn | input | 33 | Decoded word of entry 0 |
| q1_insn | input | 33 | Decoded word of entry 1 |
| stall | input | 1 | Downstream pipes cannot accept |
| flush | input | 1 | Discard issued and pending work |
| pop | output | 2 | Entries removed from the queue this cycle |
| u_valid | output | 1 | U pipe carries an instruction |
| u_insn | output | 33 | Instruction word for U |
| v_valid | output | 1 | V pipe carries an instruction |
| v_insn | output | 33 | Instruction word for V |

## Verification
The pairing decision is combinational, so a wrong dependency or class check shows up on `pop` in the same cycle. It also shows up one cycle later as a wrong `v_valid` or a wrong pipe payload. A corrupted issue register, or one that fails to hold, appears on the U or V outputs within one cycle of the stall or load that exposes it. A flush that fails to clear shows up as a stale valid on the cycle after the flush. Randomized register numbers drawn from a small range make the dependency conditions frequent.

// File: rtl/dis_pkg.sv
package dis_pkg;
  typedef enum logic [1:0] {
    ISSUE_NONE = 2'd0,
    ISSUE_ONE  = 2'd1,
    ISSUE_TWO  = 2'd2
  } issue_e;
endpackage

// File: rtl/dis_hazard.sv
module dis_hazard #(
  parameter int REG_W  = 5,
  parameter int INSN_W = 33
) (
  input  logic [INSN_W-1:0] older,
  input  logic [INSN_W-1:0] younger,
  output logic              dep
);
  localparam int SA_LO = 0;
  localparam int SB_LO = REG_W;
  localparam int DS_LO = 2 * REG_W;
  localparam int WR_B  = 3 * REG_W;

  logic [REG_W-1:0] o_dst, y_dst, y_sa, y_sb;
  logic             o_wr, y_wr;
  logic             raw, waw;

  always_comb begin
    o_dst = older[DS_LO +: REG_W];
    o_wr  = older[WR_B];
    y_dst = younger[DS_LO +: REG_W];
    y_sa  = younger[SA_LO +: REG_W];
    y_sb  = younger[SB_LO +: REG_W];
    y_wr  = younger[WR_B];
    raw   = o_wr && ((o_dst == y_sa) || (o_dst == y_sb));
    waw   = o_wr && y_wr && (o_dst == y_dst);
    dep   = raw || waw;
  end
endmodule

// File: rtl/dis_pair_decide.sv
module dis_pair_decide
  import dis_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] q_valid,
  input  logic       young_simple,
  input  logic       dep,
  input  logic       stall,
  input  logic       flush,
  output issue_e     kind,
  output logic [1:0] pop,
  output logic       ld_en,
  output logic [1:0] ld_vld
);
  always_comb begin
    if (!q_valid[0])
      kind = ISSUE_NONE;
    else if (q_valid[1] && young_simple && !dep)
      kind = ISSUE_TWO;
    else
      kind = ISSUE_ONE;
    pop       = (stall || flush) ? 2'd0 : 2'(kind);
    ld_en     = !stall;
    ld_vld[0] = (kind != ISSUE_NONE);
    ld_vld[1] = (kind == ISSUE_TWO);
  end

  // R4 R5: a dual pop never coexists with a detected dependency
  assert_dual_no_dep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop == 2'd2) |-> !dep);
  // R6: a dual pop needs a simple younger entry
  assert_dual_simple_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop == 2'd2) |-> young_simple);
endmodule

// File: rtl/dis_lane_reg.sv
module dis_lane_reg #(
  parameter int INSN_W = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              ld_en,
  input  logic              ld_vld,
  input  logic [INSN_W-1:0] ld_insn,
  output logic              vld_q,
  output logic [INSN_W-1:0] insn_q
);
  logic              vld_d;
  logic [INSN_W-1:0] insn_d;

  always_comb begin
    vld_d  = vld_q;
    insn_d = insn_q;
    if (flush) begin
      vld_d = 1'b0;
    end else if (ld_en) begin
      vld_d = ld_vld;
      if (ld_vld) insn_d = ld_insn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      insn_q <= '0;
    end else begin
      vld_q  <= vld_d;
      insn_q <= insn_d;
    end
  end

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !vld_q);
  assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !flush) |=> ($stable(vld_q) && $stable(insn_q)));
endmodule

// File: rtl/dual_issue_steer.sv
module dual_issue_steer
  import dis_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int TAG_W  = 16,
  parameter int INSN_W = TAG_W + 3 * REG_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        q_valid,
  input  logic [INSN_W-1:0] q0_insn,
  input  logic [INSN_W-1:0] q1_insn,
  input  logic              stall,
  input  logic              flush,
  output logic [1:0]        pop,
  output logic              u_valid,
  output logic [INSN_W-1:0] u_insn,
  output logic              v_valid,
  output logic [INSN_W-1:0] v_insn
);
  localparam int SIMPLE_B = 3 * REG_W + 1;
  localparam int LANES    = 2;

  logic              dep;
  issue_e            kind;
  logic              ld_en;
  logic [LANES-1:0]  ld_vld;
  logic [LANES-1:0]  lane_vld;
  logic [INSN_W-1:0] lane_src  [LANES];
  logic [INSN_W-1:0] lane_insn [LANES];

  dis_hazard #(.REG_W(REG_W), .INSN_W(INSN_W)) u_hazard (
    .older   (q0_insn),
    .younger (q1_insn),
    .dep     (dep)
  );

  dis_pair_decide u_decide (
    .clk          (clk),
    .rst_n        (rst_n),
    .q_valid      (q_valid),
    .young_simple (q1_insn[SIMPLE_B]),
    .dep          (dep),
    .stall        (stall),
    .flush        (flush),
    .kind         (kind),
    .pop          (pop),
    .ld_en        (ld_en),
    .ld_vld       (ld_vld)
  );

  assign lane_src[0] = q0_insn;
  assign lane_src[1] = q1_insn;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dis_lane_reg #(.INSN_W(INSN_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .ld_en   (ld_en),
      .ld_vld  (ld_vld[g]),
      .ld_insn (lane_src[g]),
      .vld_q   (lane_vld[g]),
      .insn_q  (lane_insn[g])
    );
  end

  always_comb begin
    u_valid = lane_vld[0] && !flush;
    v_valid = lane_vld[1] && !flush;
    u_insn  = lane_insn[0];
    v_insn  = lane_insn[1];
  end

  // R3: V never carries work without U beside it (order kept)
  assert_v_implies_u_R3: assert property (@(posedge clk) disable iff (!rst_n)
    v_valid |-> u_valid);
  // R8 R9: no pop while stalled or flushing
  assert_no_pop_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || flush) |-> (pop == 2'd0));
  // R2: empty head means no pop; never more than two
  assert_pop_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_valid[0] |-> (pop == 2'd0)) and (pop != 2'd3));
  // R9: outputs dark while flush is high
  assert_flush_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!u_valid && !v_valid));
endmodule

// File: tb/dual_issue_steer_bench.sv
module dual_issue_steer_bench;
  localparam int W = 33;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   q_valid;
  logic [W-1:0] q0_insn, q1_insn;
  logic         stall, flush;
  logic [1:0]   pop;
  logic         u_valid, v_valid;
  logic [W-1:0] u_insn, v_insn;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  bit           m_uv, m_vv;
  logic [W-1:0] m_ui, m_vi;

  always #4 clk = ~clk;

  dual_issue_steer u_dual_issue_steer (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q0_insn(q0_insn),
    .q1_insn(q1_insn), .stall(stall), .flush(flush), .pop(pop),
    .u_valid(u_valid), .u_insn(u_insn), .v_valid(v_valid), .v_insn(v_insn)
  );

  function automatic logic [W-1:0] mk(input int tag, input bit simple, input bit wr,
                                      input int dst, input int sb, input int sa);
    return {16'(tag), simple, wr, 5'(dst), 5'(sb), 5'(sa)};
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] qv, input logic [W-1:0] w0, input logic [W-1:0] w1,
                      input bit st, input bit fl, input string rq);
    int kind;
    bit dep;
    q_valid = qv; q0_insn = w0; q1_insn = w1; stall = st; flush = fl;
    #1;
    dep = w0[15] && ((w0[14:10] == w1[4:0]) || (w0[14:10] == w1[9:5]) ||
                     (w1[15] && w0[14:10] == w1[14:10]));
    if (!qv[0]) kind = 0;
    else if (qv[1] && w1[16] && !dep) kind = 2;
    else kind = 1;
    check(pop == ((st || fl) ? 2'd0 : 2'(kind)), rq, "pop", 64'(pop),
          (st || fl) ? 64'd0 : 64'(kind));
    check(u_valid == (m_uv && !fl), rq, "u_valid", 64'(u_valid), 64'(m_uv && !fl));
    check(v_valid == (m_vv && !fl), rq, "v_valid", 64'(v_valid), 64'(m_vv && !fl));
    if (m_uv && !fl) check(u_insn == m_ui, rq, "u_insn", 64'(u_insn), 64'(m_ui));
    if (m_vv && !fl) check(v_insn == m_vi, rq, "v_insn", 64'(v_insn), 64'(m_vi));
    @(posedge clk);
    if (fl) begin
      m_uv = 0; m_vv = 0;
    end else if (!st) begin
      m_uv = (kind > 0);
      m_vv = (kind == 2);
      if (kind > 0) m_ui = w0;
      if (kind == 2) m_vi = w1;
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; q_valid = 0; q0_insn = '0; q1_insn = '0; stall = 0; flush = 0;
    m_uv = 0; m_vv = 0; m_ui = '0; m_vi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    step(2'b00, '0, '0, 0, 0, "R1");
    // R3: independent pair, simple younger -> dual
    step(2'b11, mk(1, 0, 1, 3, 1, 2), mk(2, 1, 1, 4, 5, 6), 0, 0, "R3");
    step(2'b11, mk(3, 1, 1, 7, 8, 9), mk(4, 1, 1, 10, 11, 12), 0, 0, "R3");
    // R4: read-after-write on either source
    step(2'b11, mk(5, 1, 1, 6, 1, 2), mk(6, 1, 1, 9, 6, 3), 0, 0, "R4");
    step(2'b11, mk(7, 1, 1, 6, 1, 2), mk(8, 1, 1, 9, 3, 6), 0, 0, "R4");
    // R5: write-after-write
    step(2'b11, mk(9, 1, 1, 12, 1, 2), mk(10, 1, 1, 12, 3, 4), 0, 0, "R5");
    // R6: complex younger
    step(2'b11, mk(11, 1, 1, 1, 2, 3), mk(12, 0, 1, 4, 5, 6), 0, 0, "R6");
    // R7: lone head entry
    step(2'b01, mk(13, 0, 1, 1, 2, 3), mk(14, 1, 0, 0, 0, 0), 0, 0, "R7");
    // R2: head invalid but entry 1 flagged -> nothing issues
    step(2'b10, mk(15, 1, 1, 1, 2, 3), mk(16, 1, 0, 4, 5, 6), 0, 0, "R2");
    // R10: matching numbers but no write in entry 0
    step(2'b11, mk(17, 1, 0, 5, 1, 2), mk(18, 1, 1, 5, 5, 5), 0, 0, "R10");
    // R8: stall holds outputs
    step(2'b11, mk(19, 1, 1, 1, 2, 3), mk(20, 1, 1, 4, 5, 6), 0, 0, "R8");
    step(2'b11, mk(21, 1, 1, 7, 2, 3), mk(22, 1, 1, 8, 5, 6), 1, 0, "R8");
    step(2'b11, mk(23, 1, 1, 7, 2, 3), mk(24, 1, 1, 8, 5, 6), 1, 0, "R8");
    // R9: flush hides outputs now and next cycle
    step(2'b11, mk(25, 1, 1, 7, 2, 3), mk(26, 1, 1, 8, 5, 6), 0, 1, "R9");
    step(2'b00, '0, '0, 0, 0, "R9");
    // R2: randomized mix with tight register range
    for (int i = 0; i < 400; i++) begin
      step(2'($urandom_range(0, 3)),
           mk(i, 1'($urandom), 1'($urandom), $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3)),
           mk(i + 1000, 1'($urandom), 1'($urandom), $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3)),
           ($urandom_range(0, 7) == 0), ($urandom_range(0, 15) == 0), "R2");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule